// File: doc/BRIEF.md
# Phase Mismatch Redirect Unit

This unit lives beside the script sequencer of a bus-master protocol engine. When the target moves the bus into a different phase before the current transfer is done, the engine pulses a mismatch strobe. Without this unit, that event could only be reported to software as an interrupt. When the redirect feature is on, the unit does the recovery work itself. It works out how many bytes are still owed and where the data pointer now stands. It adds the moved bytes to a running per-I/O total. It then asks the sequencer to branch to one of two programmable handler addresses, after a fixed number of clock cycles.

A control byte sets the behaviour. One bit turns the feature on. A second bit chooses how the handler is picked: either by the wide-residue flag, or by the direction of the interrupted phase. A third bit lets non-data phases take the branch as well. A fourth bit turns off the automatic FIFO-clear pulse that otherwise follows an outbound data mismatch. The running byte total can be loaded with any value at any time.

Top module: `phase_redirect`

## Requirements
- R1: After reset, jump_req, irq and fifo_clr are low, and rem_count, new_ptr and tally are zero.
- R2: When ctrl_byte bit 7 is 0, an accepted mismatch strobe pulses irq high for exactly one cycle, starting the cycle after the strobe, and jump_req stays low.
- R3: When bit 7 is 1 and bit 6 is 0, the branch target is vec_a if wide_resid is 0 and vec_b if wide_resid is 1.
- R4: When bits 7 and 6 are both 1, the branch target is chosen by bit 0 of xfer_phase: 0 (data-out 000, command 010, message-out 110) selects vec_a, and 1 (data-in 001, status 011, message-in 111) selects vec_b. wide_resid is ignored in this mode.
- R5: Phases 000 and 001 are data phases, and every other phase code is a non-data phase. When bit 7 is 1 and bit 5 is 0, a mismatch in a non-data phase gives the one-cycle irq pulse and no branch. When bit 5 is 1, a non-data mismatch branches like a data mismatch.
- R6: An accepted strobe in phase 000 with ctrl_byte bit 4 at 0 gives a one-cycle fifo_clr pulse in the following cycle. With bit 4 at 1, or in any other phase, fifo_clr stays low.
- R7: One cycle after an accepted strobe, rem_count holds xfer_count minus xfer_done, taken modulo 2^24. new_ptr holds xfer_start plus xfer_done, taken modulo 2^32.
- R8: Each accepted strobe adds xfer_done to tally. A tally_load high sets tally to tally_value at the next edge, and a load wins over an add in the same cycle.
- R9: For a strobe that branches, jump_req rises exactly 16 clock edges after the edge that sampled the strobe, with jump_addr holding the selected target.
- R10: jump_req and jump_addr stay unchanged until jump_ack is sampled high. jump_req is low in the cycle after that edge.
- R11: A strobe that arrives while a branch is pending (counting down or requesting) is ignored. It produces no irq and no fifo_clr, and leaves rem_count, new_ptr, tally and the pending jump_addr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_byte | input | 8 | Control: bit 7 enable, bit 6 direction select, bit 5 non-data branch, bit 4 no auto FIFO clear |
| vec_a | input | 32 | First handler address |
| vec_b | input | 32 | Second handler address |
| xfer_phase | input | 3 | Phase of the interrupted transfer |
| wide_resid | input | 1 | Wide-residue flag |
| xfer_count | input | 24 | Programmed byte count of the transfer |
| xfer_start | input | 32 | Start data pointer of the transfer |
| xfer_done | input | 24 | Bytes already moved when the mismatch occurred |
| mm_strobe | input | 1 | Phase mismatch strobe |
| jump_ack | input | 1 | Sequencer has taken the branch |
| tally_load | input | 1 | Load the cumulative byte counter |
| tally_value | input | 32 | Value to load |
| jump_req | output | 1 | Branch request to the sequencer |
| jump_addr | output | 32 | Branch target |
| irq | output | 1 | Mismatch interrupt pulse |
| fifo_clr | output | 1 | FIFO-clear pulse |
| rem_count | output | 24 | Remaining byte count |
| new_ptr | output | 32 | Advanced data pointer |
| tally | output | 32 | Cumulative byte count |

## Verification
The assertions assume that the control byte, the handler addresses, the phase and the transfer fields are steady in the cycle the strobe is sampled. They also assume that jump_ack is only raised while a branch is being requested. The bench changes every such input on the falling edge, before it raises the strobe, and raises jump_ack only after it has seen jump_req high. It deliberately sends a strobe during a pending branch to exercise the ignore path.

// File: rtl/phase_redirect_pkg.sv
// Shared definitions for the phase mismatch redirect unit.
// Assumes a 3-bit phase code where the two data phases share upper bits 00.
package phase_redirect_pkg;

    typedef enum logic [2:0] {
        PH_DOUT = 3'b000,
        PH_DIN  = 3'b001,
        PH_CMD  = 3'b010,
        PH_STAT = 3'b011,
        PH_MOUT = 3'b110,
        PH_MIN  = 3'b111
    } bus_phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_HOLD = 2'd2
    } seq_state_e;

    localparam int CTL_ENABLE  = 7;
    localparam int CTL_DIRSEL  = 6;
    localparam int CTL_NONDATA = 5;
    localparam int CTL_NOCLR   = 4;

    // True for the two data phases
    function automatic logic is_data_phase(input logic [2:0] ph);
        return ph[2:1] == 2'b00;
    endfunction

endpackage

// File: rtl/phase_redirect_decide.sv
// Combinational decision: whether a mismatch branches or interrupts,
// which handler address applies, and whether the FIFO clear is due.
// Assumes the control bits are already split out by the caller.
module phase_redirect_decide
    import phase_redirect_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic              dir_sel,
    input  logic              nondata_ok,
    input  logic              no_clr,
    input  logic [2:0]        phase,
    input  logic              wide,
    input  logic [ADDR_W-1:0] vec_a,
    input  logic [ADDR_W-1:0] vec_b,
    output logic              take_jump,
    output logic [ADDR_W-1:0] target,
    output logic              clr_due
);

    logic pick_b;

    // Branch only when enabled, and for non-data phases only if allowed
    always_comb take_jump = en && (is_data_phase(phase) || nondata_ok);

    // Vector choice: direction bit of the phase, or the wide-residue flag
    always_comb pick_b = dir_sel ? phase[0] : wide;

    // Select the handler address
    always_comb target = pick_b ? vec_b : vec_a;

    // Auto FIFO clear on outbound data mismatches unless suppressed
    always_comb clr_due = (phase == PH_DOUT) && !no_clr;

endmodule

// File: rtl/phase_redirect_residue.sv
// Registers the remaining count and advanced pointer for the interrupted
// transfer. Assumes ADDR_W >= CNT_W; arithmetic wraps at the widths.
module phase_redirect_residue #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] start,
    input  logic [CNT_W-1:0]  done,
    output logic [CNT_W-1:0]  rem,
    output logic [ADDR_W-1:0] ptr
);

    // Capture residual state on an accepted mismatch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            ptr <= '0;
        end else if (capture) begin
            rem <= count - done;
            ptr <= start + ADDR_W'(done);
        end
    end

endmodule

// File: rtl/phase_redirect_tally.sv
// Cumulative byte counter for one I/O; loadable, load has priority.
// Assumes TALLY_W >= CNT_W; the count wraps at TALLY_W bits.
module phase_redirect_tally #(
    parameter int CNT_W   = 24,
    parameter int TALLY_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TALLY_W-1:0] load_val,
    input  logic               add,
    input  logic [CNT_W-1:0]   add_val,
    output logic [TALLY_W-1:0] total
);

    // Load or accumulate the moved bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (load) begin
            total <= load_val;
        end else if (add) begin
            total <= total + TALLY_W'(add_val);
        end
    end

endmodule

// File: rtl/phase_redirect_seq.sv
// Branch sequencer: counts a fixed latency after a branching mismatch,
// then holds the request and target until the sequencer acknowledges.
// Assumes LATENCY >= 1.
module phase_redirect_seq
    import phase_redirect_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LATENCY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] target,
    input  logic              ack,
    output logic              busy,
    output logic              req,
    output logic [ADDR_W-1:0] addr
);

    localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    // Latency countdown and request hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            req   <= 1'b0;
            addr  <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    state <= SQ_WAIT;
                    cnt   <= CW'(LATENCY - 1);
                    addr  <= target;
                end
                SQ_WAIT: if (cnt == '0) begin
                    state <= SQ_HOLD;
                    req   <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
                SQ_HOLD: if (ack) begin
                    state <= SQ_IDLE;
                    req   <= 1'b0;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Any state but idle blocks new mismatches
    always_comb busy = (state != SQ_IDLE);

endmodule

// File: rtl/phase_redirect.sv
// Phase mismatch redirect unit top. Accepts a mismatch strobe when no
// branch is pending, then either pulses the interrupt or schedules a
// branch, and always updates residue, tally and the FIFO-clear pulse.
// Assumes inputs are steady in the cycle the strobe is sampled.
module phase_redirect
    import phase_redirect_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 24,
    parameter int TALLY_W = 32,
    parameter int LATENCY = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         ctrl_byte,
    input  logic [ADDR_W-1:0]  vec_a,
    input  logic [ADDR_W-1:0]  vec_b,
    input  logic [2:0]         xfer_phase,
    input  logic               wide_resid,
    input  logic [CNT_W-1:0]   xfer_count,
    input  logic [ADDR_W-1:0]  xfer_start,
    input  logic [CNT_W-1:0]   xfer_done,
    input  logic               mm_strobe,
    input  logic               jump_ack,
    input  logic               tally_load,
    input  logic [TALLY_W-1:0] tally_value,
    output logic               jump_req,
    output logic [ADDR_W-1:0]  jump_addr,
    output logic               irq,
    output logic               fifo_clr,
    output logic [CNT_W-1:0]   rem_count,
    output logic [ADDR_W-1:0]  new_ptr,
    output logic [TALLY_W-1:0] tally
);

    logic              busy;
    logic              accept;
    logic              take_jump;
    logic              clr_due;
    logic [ADDR_W-1:0] target;
    logic              ctrl_unused;

    // Low control bits are reserved
    always_comb ctrl_unused = ^ctrl_byte[3:0];

    // A strobe counts only when no branch is pending
    always_comb accept = mm_strobe && !busy;

    phase_redirect_decide #(.ADDR_W(ADDR_W)) u_decide (
        .en         (ctrl_byte[CTL_ENABLE]),
        .dir_sel    (ctrl_byte[CTL_DIRSEL]),
        .nondata_ok (ctrl_byte[CTL_NONDATA]),
        .no_clr     (ctrl_byte[CTL_NOCLR]),
        .phase      (xfer_phase),
        .wide       (wide_resid),
        .vec_a      (vec_a),
        .vec_b      (vec_b),
        .take_jump  (take_jump),
        .target     (target),
        .clr_due    (clr_due)
    );

    phase_redirect_residue #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_residue (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .count   (xfer_count),
        .start   (xfer_start),
        .done    (xfer_done),
        .rem     (rem_count),
        .ptr     (new_ptr)
    );

    phase_redirect_tally #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tally_load),
        .load_val (tally_value),
        .add      (accept),
        .add_val  (xfer_done),
        .total    (tally)
    );

    phase_redirect_seq #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept && take_jump),
        .target (target),
        .ack    (jump_ack),
        .busy   (busy),
        .req    (jump_req),
        .addr   (jump_addr)
    );

    // One-cycle interrupt and FIFO-clear pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            fifo_clr <= 1'b0;
        end else begin
            irq      <= accept && !take_jump;
            fifo_clr <= accept && clr_due;
        end
    end

endmodule

// File: rtl/phase_redirect_chk.sv
// Property checker for the redirect unit, bound into every instance.
// Assumes jump_ack is only raised while a request is up.
module phase_redirect_chk #(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 24,
    parameter int LATENCY = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mm_strobe,
    input logic              busy,
    input logic              take_jump,
    input logic              enable,
    input logic              no_clr,
    input logic [2:0]        xfer_phase,
    input logic              jump_ack,
    input logic              jump_req,
    input logic [ADDR_W-1:0] jump_addr,
    input logic              irq,
    input logic              fifo_clr,
    input logic [CNT_W-1:0]  rem_count,
    input logic [ADDR_W-1:0] new_ptr
);

    localparam int LIM = LATENCY + 1;
    localparam int LW  = $clog2(LIM + 1);

    logic [LW-1:0] lat_cnt;

    // Edges elapsed since a branching strobe, saturating past the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (mm_strobe && !busy && take_jump) begin
            lat_cnt <= LW'(1);
        end else if (lat_cnt != '0 && lat_cnt < LW'(LIM)) begin
            lat_cnt <= lat_cnt + LW'(1);
        end
    end

    // R2
    disabled_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_strobe && !busy && !enable) |=> (irq && !jump_req));

    // R6
    fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_strobe && !busy && xfer_phase == 3'b000 && !no_clr) |=> fifo_clr);

    // R9
    jump_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jump_req) |-> (lat_cnt == LW'(LIM)));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_req && !jump_ack) |=> (jump_req && $stable(jump_addr)));

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_req && jump_ack) |=> !jump_req);

    // R11
    pending_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_strobe && busy) |=> ($stable(rem_count) && $stable(new_ptr) && !irq && !fifo_clr));

endmodule

bind phase_redirect phase_redirect_chk #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .LATENCY (LATENCY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mm_strobe  (mm_strobe),
    .busy       (busy),
    .take_jump  (take_jump),
    .enable     (ctrl_byte[7]),
    .no_clr     (ctrl_byte[4]),
    .xfer_phase (xfer_phase),
    .jump_ack   (jump_ack),
    .jump_req   (jump_req),
    .jump_addr  (jump_addr),
    .irq        (irq),
    .fifo_clr   (fifo_clr),
    .rem_count  (rem_count),
    .new_ptr    (new_ptr)
);

// File: tb/sim_phase_redirect.sv
`timescale 1ns/1ps
// Directed bench for the phase mismatch redirect unit.
module sim_phase_redirect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctrl_byte = 8'h00;
    logic [31:0] vec_a = 32'hA000_0100;
    logic [31:0] vec_b = 32'hB000_0200;
    logic [2:0]  xfer_phase = 3'b000;
    logic        wide_resid = 1'b0;
    logic [23:0] xfer_count = 24'd0;
    logic [31:0] xfer_start = 32'd0;
    logic [23:0] xfer_done = 24'd0;
    logic        mm_strobe = 1'b0;
    logic        jump_ack = 1'b0;
    logic        tally_load = 1'b0;
    logic [31:0] tally_value = 32'd0;
    logic        jump_req;
    logic [31:0] jump_addr;
    logic        irq;
    logic        fifo_clr;
    logic [23:0] rem_count;
    logic [31:0] new_ptr;
    logic [31:0] tally;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    phase_redirect u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .vec_a(vec_a), .vec_b(vec_b),
        .xfer_phase(xfer_phase), .wide_resid(wide_resid), .xfer_count(xfer_count),
        .xfer_start(xfer_start), .xfer_done(xfer_done), .mm_strobe(mm_strobe),
        .jump_ack(jump_ack), .tally_load(tally_load), .tally_value(tally_value),
        .jump_req(jump_req), .jump_addr(jump_addr), .irq(irq), .fifo_clr(fifo_clr),
        .rem_count(rem_count), .new_ptr(new_ptr), .tally(tally)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe for one cycle; returns at the falling edge after the sampling edge
    task automatic strobe_once();
        @(negedge clk);
        mm_strobe = 1'b1;
        @(negedge clk);
        mm_strobe = 1'b0;
    endtask

    // After strobe_once, wait out the latency and check the branch, then acknowledge
    task automatic expect_jump(input string req, input logic [31:0] exp_addr);
        chk(req, {31'd0, irq}, 32'd0);
        repeat (15) @(negedge clk);
        chk({req, " R9 before"}, {31'd0, jump_req}, 32'd0);
        @(negedge clk);
        chk({req, " R9 at 16"}, {31'd0, jump_req}, 32'd1);
        chk(req, jump_addr, exp_addr);
        jump_ack = 1'b1;
        @(negedge clk);
        jump_ack = 1'b0;
        chk({req, " R10 drop"}, {31'd0, jump_req}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 jump_req", {31'd0, jump_req}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 fifo_clr", {31'd0, fifo_clr}, 32'd0);
        chk("R1 rem", {8'd0, rem_count}, 32'd0);
        chk("R1 ptr", new_ptr, 32'd0);
        chk("R1 tally", tally, 32'd0);
    endtask

    task automatic t_disabled();
        ctrl_byte = 8'h00; xfer_phase = 3'b001;
        strobe_once();
        chk("R2 irq", {31'd0, irq}, 32'd1);
        chk("R2 no jump", {31'd0, jump_req}, 32'd0);
        @(negedge clk);
        chk("R2 pulse width", {31'd0, irq}, 32'd0);
        repeat (17) @(negedge clk);
        chk("R2 still no jump", {31'd0, jump_req}, 32'd0);
    endtask

    task automatic t_wide_select();
        ctrl_byte = 8'h80; xfer_phase = 3'b001; wide_resid = 1'b0;
        strobe_once(); expect_jump("R3 wide0", vec_a);
        wide_resid = 1'b1;
        strobe_once(); expect_jump("R3 wide1", vec_b);
    endtask

    task automatic t_dir_select();
        ctrl_byte = 8'hC0; xfer_phase = 3'b000; wide_resid = 1'b1;
        strobe_once(); expect_jump("R4 out", vec_a);
        xfer_phase = 3'b001; wide_resid = 1'b0;
        strobe_once(); expect_jump("R4 in", vec_b);
    endtask

    task automatic t_nondata();
        ctrl_byte = 8'h80; xfer_phase = 3'b011;
        strobe_once();
        chk("R5 irq", {31'd0, irq}, 32'd1);
        repeat (17) @(negedge clk);
        chk("R5 no jump", {31'd0, jump_req}, 32'd0);
        ctrl_byte = 8'hE0; xfer_phase = 3'b111;
        strobe_once(); expect_jump("R5 msg-in", vec_b);
        xfer_phase = 3'b010;
        strobe_once(); expect_jump("R5 command", vec_a);
    endtask

    task automatic t_fifo();
        ctrl_byte = 8'h00; xfer_phase = 3'b000;
        strobe_once();
        chk("R6 clear", {31'd0, fifo_clr}, 32'd1);
        @(negedge clk);
        chk("R6 one cycle", {31'd0, fifo_clr}, 32'd0);
        ctrl_byte = 8'h10;
        strobe_once();
        chk("R6 suppressed", {31'd0, fifo_clr}, 32'd0);
        ctrl_byte = 8'h00; xfer_phase = 3'b001;
        strobe_once();
        chk("R6 data-in", {31'd0, fifo_clr}, 32'd0);
    endtask

    task automatic t_residue();
        ctrl_byte = 8'h00; xfer_phase = 3'b001;
        xfer_count = 24'd1000; xfer_done = 24'd300; xfer_start = 32'h0000_1000;
        strobe_once();
        chk("R7 rem", {8'd0, rem_count}, 32'd700);
        chk("R7 ptr", new_ptr, 32'h0000_112C);
        xfer_count = 24'd5; xfer_done = 24'd9; xfer_start = 32'hFFFF_FFFC;
        strobe_once();
        chk("R7 rem wrap", {8'd0, rem_count}, 32'h00FF_FFFC);
        chk("R7 ptr wrap", new_ptr, 32'h0000_0005);
    endtask

    task automatic t_tally();
        ctrl_byte = 8'h00;
        @(negedge clk);
        tally_load = 1'b1; tally_value = 32'd100;
        @(negedge clk);
        tally_load = 1'b0;
        chk("R8 load", tally, 32'd100);
        xfer_done = 24'd300;
        strobe_once();
        chk("R8 add", tally, 32'd400);
        @(negedge clk);
        tally_load = 1'b1; tally_value = 32'd7; mm_strobe = 1'b1;
        @(negedge clk);
        tally_load = 1'b0; mm_strobe = 1'b0;
        chk("R8 load wins", tally, 32'd7);
    endtask

    task automatic t_pending();
        ctrl_byte = 8'h80; xfer_phase = 3'b000; wide_resid = 1'b0;
        xfer_count = 24'd1000; xfer_done = 24'd300; xfer_start = 32'h0000_1000;
        strobe_once();
        // second strobe one edge later, with other fields and an irq-mode control
        ctrl_byte = 8'h00; xfer_done = 24'd50; wide_resid = 1'b1;
        mm_strobe = 1'b1;
        @(negedge clk);
        mm_strobe = 1'b0;
        chk("R11 no irq", {31'd0, irq}, 32'd0);
        chk("R11 no fifo_clr", {31'd0, fifo_clr}, 32'd0);
        chk("R11 rem kept", {8'd0, rem_count}, 32'd700);
        chk("R11 ptr kept", new_ptr, 32'h0000_112C);
        chk("R11 tally kept", tally, 32'd307);
        repeat (14) @(negedge clk);
        chk("R9 pending before", {31'd0, jump_req}, 32'd0);
        @(negedge clk);
        chk("R9 pending at 16", {31'd0, jump_req}, 32'd1);
        chk("R11 addr kept", jump_addr, vec_a);
        // hold without acknowledge, strobing again during the request
        mm_strobe = 1'b1;
        repeat (4) @(negedge clk);
        mm_strobe = 1'b0;
        chk("R10 held", {31'd0, jump_req}, 32'd1);
        chk("R10 addr stable", jump_addr, vec_a);
        chk("R11 tally during hold", tally, 32'd307);
        jump_ack = 1'b1;
        @(negedge clk);
        jump_ack = 1'b0;
        chk("R10 released", {31'd0, jump_req}, 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_wide_select();
        t_dir_select();
        t_nondata();
        t_fifo();
        t_residue();
        t_tally();
        t_pending();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule